// File: doc/BRIEF.md
# Serial Port Power-Save Gate

This controller decides, cycle by cycle, whether a modem's serial port may be powered and may move data. While power saving is on, the port sleeps most of the time and opens short wake windows. In the slower cellular mode (2G) a window opens together with a paging reception, but only once a minimum sleep gap has passed. In the faster mode (3G) the windows follow a free-running on/off duty cycle that takes no notice of paging. A character that arrives during a window, or transmit activity, keeps the port open. The port then stays open until a programmable period with no traffic has passed. That period is given in radio frames of 4.615 ms.

All timing runs on a single 1 ms timebase strobe. The inactivity timeout in frames is clamped to its legal range and converted to ticks (frames × 4615 / 1000, rounded up). The converted value is captured each time the port goes from disabled to enabled. Every pin is a level or a one-cycle strobe, and nothing is queued. There is no data stream through the block, so there is no back-pressure: a strobe that arrives while the port is asleep is dropped.

An idle host forces the port off at once. Turning power saving off forces it on. When hardware flow control is enabled, an active-low clear-to-send line mirrors the enable.

Top module: `uart_psave_gate`

## Requirements
- R1: While reset is held with power saving on, the port is disabled, the lingering indication is low, and with flow control on the clear-to-send line is high.
- R2: In 3G mode (`net_3g_i`=1) the port sleeps OFF3G_TICKS ticks after reset or after any disable, is then enabled for WAKE_TICKS ticks, and repeats. Paging strobes have no effect in this mode.
- R3: In 2G mode (`net_3g_i`=0) a window opens on the edge that samples `paging_i` high, but only if at least GAP2G_TICKS ticks have passed since the port was disabled. Earlier pages are ignored. A window with no traffic lasts WAKE_TICKS ticks.
- R4: A receive or transmit strobe while the port is enabled moves it into lingering on that edge (`linger_o`=1), and the port stays enabled.
- R5: While lingering, the port is disabled exactly T ticks after the last activity strobe, and each further strobe restarts the full T.
- R6: T = ceil(F × 4615 / 1000), where F is `timeout_frames_i` clamped to [40, 65000]. F is sampled on the edge where the port goes from disabled to enabled, so a later change has no effect until the next wake.
- R7: Receive and transmit strobes while the port is disabled are ignored. They neither enable the port nor alter the following window.
- R8: With power saving on, a high `host_idle_i` disables the port and clears lingering in the same cycle. A new sleep phase counts from the last edge that sampled it high.
- R9: With power saving off, the port is enabled and the clear-to-send line is low. After re-enabling, a new sleep phase counts from the last edge that sampled it off.
- R10: The clear-to-send line is the inverse of the port enable when `hwfc_en_i`=1, and is held low when `hwfc_en_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 1 ms timebase strobe |
| paging_i | input | 1 | Paging reception strobe |
| net_3g_i | input | 1 | Network mode: 1 = 3G, 0 = 2G |
| host_idle_i | input | 1 | Host is in idle mode |
| rx_char_i | input | 1 | Character received strobe |
| tx_act_i | input | 1 | Transmit activity strobe |
| psave_en_i | input | 1 | Power saving enable |
| hwfc_en_i | input | 1 | Hardware flow control enable |
| timeout_frames_i | input | FR_W | Inactivity timeout in frames |
| port_en_o | output | 1 | Serial port enabled |
| linger_o | output | 1 | Port held open by recent traffic |
| cts_n_o | output | 1 | Active-low clear-to-send |

## Verification
A wrong sleep counter shifts the edge where the first window opens. It therefore shows on `port_en_o` within one sleep phase, which takes a dozen edges in the small bench configuration. A faulty window counter changes the window length on the very first window. A latching or rounding fault in the timeout conversion shifts the end of lingering by a few ticks: 40 and 41 frames differ by five ticks, which is visible at the single edge where the port closes. Override faults (idle, power saving off) show in the same cycle, or as a misplaced next window.

// File: rtl/ups_pkg.sv
package ups_pkg;

  typedef enum logic [1:0] {
    PH_SLEEP  = 2'd0,
    PH_WAKE   = 2'd1,
    PH_LINGER = 2'd2
  } phase_e;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

endpackage

// File: rtl/ups_frame_conv.sv
module ups_frame_conv #(
  parameter int FR_W   = 16,
  parameter int FR_MIN = 40,
  parameter int FR_MAX = 65000,
  parameter int NUM    = 4615,
  parameter int DEN    = 1000,
  parameter int TK_W   = 19
) (
  input  logic [FR_W-1:0] frames_i,
  output logic [TK_W-1:0] ticks_o
);

  localparam int NUM_W  = $clog2(NUM + 1);
  localparam int PROD_W = FR_W + NUM_W + 1;

  logic [FR_W-1:0]   fr_c;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quo;

  // clamp into the legal frame range
  always_comb begin
    if (frames_i < FR_W'(FR_MIN))      fr_c = FR_W'(FR_MIN);
    else if (frames_i > FR_W'(FR_MAX)) fr_c = FR_W'(FR_MAX);
    else                               fr_c = frames_i;
  end

  // frames to ticks, rounded up
  always_comb begin
    prod    = PROD_W'(fr_c) * PROD_W'(NUM) + PROD_W'(DEN - 1);
    quo     = prod / PROD_W'(DEN);
    ticks_o = TK_W'(quo);
  end

endmodule

// File: rtl/ups_sleep_timer.sv
module ups_sleep_timer #(
  parameter int GAP_TICKS = 2000,
  parameter int OFF_TICKS = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic net_3g,
  input  logic paging,
  output logic wake_go
);

  localparam int CNT_MAX = (GAP_TICKS > OFF_TICKS - 1) ? GAP_TICKS : OFF_TICKS - 1;
  localparam int CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] elapsed_q;

  // ticks spent asleep, saturating; cleared whenever not sleeping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     elapsed_q <= '0;
    else if (!run)                                  elapsed_q <= '0;
    else if (tick && elapsed_q != CNT_W'(CNT_MAX))  elapsed_q <= elapsed_q + 1'b1;
  end

  always_comb begin
    wake_go = 1'b0;
    if (run) begin
      if (net_3g) wake_go = tick && (elapsed_q >= CNT_W'(OFF_TICKS - 1));
      else        wake_go = paging && (elapsed_q >= CNT_W'(GAP_TICKS));
    end
  end

  // R3: the sleep counter never runs past its saturation point
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(elapsed_q) <= CNT_MAX);

  // R2: the free-running wake only fires on a timebase strobe
  p_3g_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_go && net_3g) |-> tick);

endmodule

// File: rtl/ups_linger_timer.sv
module ups_linger_timer #(
  parameter int TK_W = 19
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            run,
  input  logic            load,
  input  logic [TK_W-1:0] load_val,
  output logic            expire
);

  logic [TK_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rem_q <= '0;
    else if (load)                   rem_q <= load_val;
    else if (!run)                   rem_q <= '0;
    else if (tick && rem_q != '0)    rem_q <= rem_q - 1'b1;
  end

  assign expire = run && !load && tick && (rem_q <= TK_W'(1));

  // R5: without a reload the remaining time only shrinks
  p_no_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load) |=> (rem_q <= $past(rem_q)));

endmodule

// File: rtl/ups_phase_fsm.sv
module ups_phase_fsm
  import ups_pkg::*;
#(
  parameter int WAKE_TICKS = 20
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   hold,
  input  logic   wake_go,
  input  logic   activity,
  input  logic   linger_done,
  output phase_e phase_o
);

  localparam int WC_W = (WAKE_TICKS < 3) ? 1 : $clog2(WAKE_TICKS);

  phase_e          phase_q, phase_d;
  logic [WC_W-1:0] wcnt_q, wcnt_d;

  always_comb begin
    phase_d = phase_q;
    wcnt_d  = wcnt_q;
    if (hold) begin
      phase_d = PH_SLEEP;
      wcnt_d  = '0;
    end else begin
      unique case (phase_q)
        PH_SLEEP: if (wake_go) begin
          phase_d = PH_WAKE;
          wcnt_d  = '0;
        end
        PH_WAKE: begin
          if (activity) phase_d = PH_LINGER;
          else if (tick) begin
            if (wcnt_q == WC_W'(WAKE_TICKS - 1)) phase_d = PH_SLEEP;
            else                                 wcnt_d  = wcnt_q + 1'b1;
          end
        end
        PH_LINGER: if (linger_done) phase_d = PH_SLEEP;
        default: phase_d = PH_SLEEP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SLEEP;
      wcnt_q  <= '0;
    end else begin
      phase_q <= phase_d;
      wcnt_q  <= wcnt_d;
    end
  end

  assign phase_o = phase_q;

  // R2: the window counter stays inside the window length
  p_wcnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(wcnt_q) < WAKE_TICKS);

  // R4: traffic inside a window turns it into lingering
  p_act_linger_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && phase_q == PH_WAKE && activity) |=> (phase_q == PH_LINGER));

  // R8: an override always lands the sequencer asleep
  p_hold_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (phase_q == PH_SLEEP));

endmodule

// File: rtl/uart_psave_gate.sv
module uart_psave_gate
  import ups_pkg::*;
#(
  parameter int FR_W        = 16,
  parameter int FR_MIN      = 40,
  parameter int FR_MAX      = 65000,
  parameter int FR_DEF      = 2000,
  parameter int FRAME_NUM   = 4615,
  parameter int FRAME_DEN   = 1000,
  parameter int WAKE_TICKS  = 20,
  parameter int GAP2G_TICKS = 2000,
  parameter int OFF3G_TICKS = 2500
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            paging_i,
  input  logic            net_3g_i,
  input  logic            host_idle_i,
  input  logic            rx_char_i,
  input  logic            tx_act_i,
  input  logic            psave_en_i,
  input  logic            hwfc_en_i,
  input  logic [FR_W-1:0] timeout_frames_i,
  output logic            port_en_o,
  output logic            linger_o,
  output logic            cts_n_o
);

  localparam int TICK_MIN = ceil_div(FR_MIN * FRAME_NUM, FRAME_DEN);
  localparam int TICK_MAX = ceil_div(FR_MAX * FRAME_NUM, FRAME_DEN);
  localparam int TICK_DEF = ceil_div(FR_DEF * FRAME_NUM, FRAME_DEN);
  localparam int TK_W     = $clog2(TICK_MAX + 1);

  logic            hold;
  logic            activity;
  logic            wake_go;
  logic            linger_done;
  logic            sleep_run;
  logic            linger_run;
  logic            linger_load;
  phase_e          phase;
  logic [TK_W-1:0] conv_ticks;
  logic [TK_W-1:0] tk_q;

  assign hold        = !psave_en_i || host_idle_i;
  assign activity    = rx_char_i || tx_act_i;
  assign sleep_run   = !hold && (phase == PH_SLEEP);
  assign linger_run  = !hold && (phase == PH_LINGER);
  assign linger_load = !hold && activity && (phase != PH_SLEEP);

  ups_frame_conv #(
    .FR_W(FR_W), .FR_MIN(FR_MIN), .FR_MAX(FR_MAX),
    .NUM(FRAME_NUM), .DEN(FRAME_DEN), .TK_W(TK_W)
  ) u_conv (
    .frames_i (timeout_frames_i),
    .ticks_o  (conv_ticks)
  );

  ups_sleep_timer #(
    .GAP_TICKS(GAP2G_TICKS), .OFF_TICKS(OFF3G_TICKS)
  ) u_sleep (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_i),
    .run     (sleep_run),
    .net_3g  (net_3g_i),
    .paging  (paging_i),
    .wake_go (wake_go)
  );

  ups_linger_timer #(.TK_W(TK_W)) u_linger (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_i),
    .run      (linger_run),
    .load     (linger_load),
    .load_val (tk_q),
    .expire   (linger_done)
  );

  ups_phase_fsm #(.WAKE_TICKS(WAKE_TICKS)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick_i),
    .hold        (hold),
    .wake_go     (wake_go),
    .activity    (activity),
    .linger_done (linger_done),
    .phase_o     (phase)
  );

  // timeout captured on every disabled-to-enabled transition
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           tk_q <= TK_W'(TICK_DEF);
    else if (sleep_run && wake_go)        tk_q <= conv_ticks;
  end

  assign port_en_o = !psave_en_i || (!host_idle_i && phase != PH_SLEEP);
  assign linger_o  = psave_en_i && !host_idle_i && phase == PH_LINGER;
  assign cts_n_o   = hwfc_en_i && !port_en_o;

  // R3: in 2G mode a window only opens on a sampled page
  p_page_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_SLEEP && phase == PH_WAKE && !$past(net_3g_i)) |-> $past(paging_i));

  // R6: captured timeout always lies in the converted legal range
  p_tk_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(tk_q) >= TICK_MIN) && (32'(tk_q) <= TICK_MAX));

  // R8: idle host never sees an open port
  p_idle_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (psave_en_i && host_idle_i) |-> (!port_en_o && !linger_o));

  // R4: lingering implies an open port
  p_linger_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    linger_o |-> port_en_o);

endmodule

// File: tb/uart_psave_gate_test.sv
module uart_psave_gate_test;

  localparam int WK  = 4;
  localparam int GAP = 10;
  localparam int OFF = 12;

  logic        clk = 1'b0;
  logic        rst_n, tick, paging, net_3g, idle, rx, tx, psave, hwfc;
  logic [15:0] frames;
  logic        port_en, linger, cts_n;

  int checks = 0;
  int errors = 0;
  int n      = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  uart_psave_gate #(
    .WAKE_TICKS(WK), .GAP2G_TICKS(GAP), .OFF3G_TICKS(OFF)
  ) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .paging_i(paging), .net_3g_i(net_3g),
    .host_idle_i(idle), .rx_char_i(rx), .tx_act_i(tx), .psave_en_i(psave),
    .hwfc_en_i(hwfc), .timeout_frames_i(frames),
    .port_en_o(port_en), .linger_o(linger), .cts_n_o(cts_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s edge %0d: got %b expected %b", req, n, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    n++;
    @(negedge clk);
  endtask

  task automatic do_reset(input bit m3g, input bit ps, input bit hw, input int fr);
    rst_n = 1'b0; tick = 1'b1; paging = 1'b0; rx = 1'b0; tx = 1'b0; idle = 1'b0;
    net_3g = m3g; psave = ps; hwfc = hw; frames = 16'(fr);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n = 0;
  endtask

  function automatic bit exp3g(input int e, input int s);
    return (e >= s + OFF) && (((e - s - OFF) % (OFF + WK)) < WK);
  endfunction

  // wake at edge 12, rx at edge 13, lingering T ticks, then free-running again
  task automatic run_linger(input int fr, input int t_exp, input string req);
    do_reset(1'b1, 1'b1, 1'b1, fr);
    while (n < 12) step();
    rx = 1'b1;
    step();
    rx = 1'b0;
    chk("R4", linger, 1'b1);
    while (n < 13 + t_exp + 40) begin
      step();
      chk(req, port_en, (n < 13 + t_exp) ? 1'b1 : exp3g(n, 13 + t_exp));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: values under reset
    rst_n = 1'b0; tick = 1'b1; paging = 1'b0; rx = 1'b0; tx = 1'b0; idle = 1'b0;
    net_3g = 1'b1; psave = 1'b1; hwfc = 1'b1; frames = 16'd40;
    repeat (2) @(negedge clk);
    chk("R1", port_en, 1'b0);
    chk("R1", linger, 1'b0);
    chk("R1", cts_n, 1'b1);

    // R2 and R10: 3G duty cycle, paging strobes must not matter
    do_reset(1'b1, 1'b1, 1'b1, 40);
    for (int i = 0; i < 80; i++) begin
      paging = ((n + 1) % 5 == 0);
      step();
      chk("R2", port_en, exp3g(n, 0));
      chk("R10", cts_n, !exp3g(n, 0));
    end

    // R3: 2G paging sweep over several paging periods
    for (int k = 0; k < 5; k++) begin
      int per;
      int s;
      int w;
      bit awake;
      per = (k == 0) ? 3 : (k == 1) ? 4 : (k == 2) ? 7 : (k == 3) ? 11 : 13;
      do_reset(1'b0, 1'b1, 1'b1, 40);
      s = 0; w = 0; awake = 1'b0;
      for (int i = 0; i < 120; i++) begin
        paging = ((n + 1) % per == 0);
        step();
        if (awake && n == w + WK) begin
          awake = 1'b0;
          s = n;
        end else if (!awake && (n % per == 0) && (n - 1 - s) >= GAP) begin
          awake = 1'b1;
          w = n;
        end
        chk("R3", port_en, awake);
      end
      paging = 1'b0;
    end

    // R5 and R6: restart by transmit; timeout changed after capture is not used
    do_reset(1'b1, 1'b1, 1'b1, 40);
    while (n < 12) step();
    rx = 1'b1;
    frames = 16'd41;
    step();
    rx = 1'b0;
    chk("R4", linger, 1'b1);
    chk("R4", port_en, 1'b1);
    while (n < 250) begin
      tx = (n == 59);
      step();
      chk("R5", port_en, n < 245);
      chk("R6", linger, n < 245);
    end
    tx = 1'b0;

    // R6: rounding (41 frames -> 190 ticks) and clamp (5 frames -> 185 ticks)
    run_linger(41, 190, "R6");
    run_linger(5, 185, "R6");

    // R7: traffic while asleep is dropped
    do_reset(1'b1, 1'b1, 1'b1, 40);
    while (n < 40) begin
      rx = (n == 4);
      tx = (n == 7);
      step();
      chk("R7", port_en, exp3g(n, 0));
      chk("R7", linger, 1'b0);
    end
    rx = 1'b0; tx = 1'b0;

    // R8: idle cuts a lingering port in the same cycle
    do_reset(1'b1, 1'b1, 1'b1, 40);
    while (n < 12) step();
    rx = 1'b1;
    step();
    rx = 1'b0;
    while (n < 49) step();
    chk("R8", linger, 1'b1);
    idle = 1'b1;
    #1;
    chk("R8", port_en, 1'b0);
    chk("R8", linger, 1'b0);
    chk("R8", cts_n, 1'b1);
    while (n < 60) begin
      step();
      chk("R8", port_en, 1'b0);
    end
    idle = 1'b0;
    while (n < 100) begin
      step();
      chk("R8", port_en, exp3g(n, 60));
    end

    // R9: power saving off keeps the port open
    do_reset(1'b1, 1'b0, 1'b1, 40);
    while (n < 30) begin
      step();
      chk("R9", port_en, 1'b1);
      chk("R9", cts_n, 1'b0);
    end
    psave = 1'b1;
    #1;
    chk("R9", port_en, 1'b0);
    while (n < 70) begin
      step();
      chk("R9", port_en, exp3g(n, 30));
    end

    // R10: flow control off holds CTS low even when asleep
    do_reset(1'b1, 1'b1, 1'b0, 40);
    while (n < 40) begin
      step();
      chk("R10", cts_n, 1'b0);
      chk("R10", port_en, exp3g(n, 0));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule